// File: doc/BRIEF.md
# Mapped DMA Block Transfer Engine

This block moves a run of bytes or 16-bit words between a streaming device-side data port and system memory. It takes a start bus address, a byte count, a direction, a byte/word choice and a map-enable flag. Each step either passes the bus address through an external address translator (mapped mode) or presents it directly as a physical address (physical mode). Memory accesses complete in the cycle they are issued. The installed memory size is a runtime input, and an address is valid only when it is strictly below that size.

A start address at or above the register-page base, compared before trimming, is handled differently. Those transfers go to a register-bus port one element at a time, and an error response from that port ends the run. When a run finishes, the engine raises `done` for one cycle and presents the number of bytes that were not moved.

Top module: `dma_xfer_engine`

## Requirements
- R1: Outside the register page, the start address is cut to its low 18 bits when WIDE=0 (the default), or 22 bits when WIDE=1, before any memory address is formed.
- R2: In word mode (`word_mode`=1), bit 0 of the address and bit 0 of the count are cleared, and the address steps by 2 per element. In byte mode it steps by 1.
- R3: With `map_en`=1, every element's bus address appears on `xlat_addr`, and memory is accessed at the returned `xlat_pa`.
- R4: With `map_en`=1, the run stops at the first translated address not below `mem_size`, and nothing is accessed there. The residual is the end address (trimmed start plus count) minus the current bus address. A run with no fault returns residual 0.
- R5: With `map_en`=0, when the end address is below `mem_size`, every element is moved and the residual is 0.
- R6: With `map_en`=0, when the start is below `mem_size` but the end is not, elements are moved only below `mem_size`, and the residual is the end minus `mem_size`.
- R7: With `map_en`=0, when the start is not below `mem_size`, no access occurs and the residual is the original count.
- R8: With a start address at or above the register-page base (default 0x3FE000), accesses use only the register-bus port. In word mode, an odd address or odd count causes no access and returns the original count as the residual.
- R9: A byte read from the register page presents the even word address and returns the high byte (`rb_rdata[15:8]`) for an odd address and the low byte otherwise. A byte write presents the exact byte address with `rb_byte`=1 and the byte in `rb_wdata[7:0]`.
- R10: When `rb_err` is returned for a register access, that element is not transferred, the run ends, and the residual is the count still remaining, including that element.
- R11: `done` is high for exactly one cycle with `residual` valid. A `start` while `busy` (including the `done` cycle) is ignored.
- R12: With `dir_wr`=0, each element read is delivered on `st_out_data` with `st_out_valid`. With `dir_wr`=1, each element written is taken from `st_in_data` with one `st_in_take` pulse. Byte data sits in bits [7:0], and the upper bits are zero.
- R13: After reset the engine is idle: `busy`, `done`, `mem_req` and `rb_req` are low and `residual` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (taken only when idle) |
| start_addr | input | ADDR_W | Start bus address |
| start_count | input | CNT_W | Byte count |
| dir_wr | input | 1 | 1: stream to memory/registers, 0: memory/registers to stream |
| word_mode | input | 1 | 1: 16-bit words, 0: bytes |
| map_en | input | 1 | 1: translate each address |
| mem_size | input | ADDR_W+1 | Installed memory size in bytes |
| busy | output | 1 | Engine not idle |
| done | output | 1 | One-cycle completion pulse |
| residual | output | CNT_W | Bytes not moved |
| xlat_addr | output | ADDR_W | Bus address offered to the translator |
| xlat_pa | input | ADDR_W | Translated physical address |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory write |
| mem_byte | output | 1 | Byte-size memory access |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data (same cycle) |
| rb_req | output | 1 | Register-bus access this cycle |
| rb_we | output | 1 | Register write |
| rb_byte | output | 1 | Byte-size register write |
| rb_addr | output | ADDR_W | Register address |
| rb_wdata | output | 16 | Register write data |
| rb_rdata | input | 16 | Register read data (same cycle) |
| rb_err | input | 1 | Register access error (same cycle) |
| st_out_valid | output | 1 | Element delivered to the stream |
| st_out_data | output | 16 | Delivered element |
| st_in_take | output | 1 | Element consumed from the stream |
| st_in_data | input | 16 | Element offered by the stream |

## Verification
Two events can fall in the same cycle: the one-cycle completion pulse and a new `start` request. The bench raises `start` with different parameters in exactly the cycle where `done` is seen, and also partway through a run. It then judges that the engine returns to idle with no access and keeps the original result. A second coincidence is a translator fault on what would have been the last element. Random map tables and memory sizes that are not page-aligned provoke it. The bench checks that the residual then counts from the faulting address and that no access is made there.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_MEM, ST_IO, ST_DONE} dma_state_e;
  typedef enum logic [1:0] {PK_MEM, PK_IO, PK_REJECT} plan_kind_e;
endpackage

// File: rtl/dma_plan.sv
module dma_plan
  import dma_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int CNT_W = 16,
  parameter int NARROW_W = 18,
  parameter bit WIDE = 1'b0,
  parameter logic [31:0] IOPG_BASE = 32'h003F_E000
) (
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  start_count,
  input  logic              word_mode,
  input  logic              map_en,
  input  logic [ADDR_W:0]   mem_size,
  output plan_kind_e        p_kind,
  output logic [ADDR_W:0]   p_first,
  output logic [ADDR_W:0]   p_lim,
  output logic [ADDR_W:0]   p_stop
);
  localparam int LIM_W = ADDR_W + 1;
  localparam int BUS_W = WIDE ? ADDR_W : NARROW_W;

  // keep only the bus-width bits of an address
  function automatic logic [LIM_W-1:0] bus_trim(input logic [ADDR_W-1:0] a);
    logic [LIM_W-1:0] m;
    m = '0;
    m[BUS_W-1:0] = a[BUS_W-1:0];
    return m;
  endfunction

  function automatic logic [LIM_W-1:0] align(input logic [LIM_W-1:0] a, input logic w);
    logic [LIM_W-1:0] r;
    r = a;
    if (w) r[0] = 1'b0;
    return r;
  endfunction

  function automatic logic [LIM_W-1:0] span(input logic [CNT_W-1:0] c, input logic w);
    logic [LIM_W-1:0] s;
    s = LIM_W'(c);
    if (w) s[0] = 1'b0;
    return s;
  endfunction

  logic              io_hit;
  logic [LIM_W-1:0]  base;
  logic [LIM_W-1:0]  lim;

  always_comb begin
    io_hit  = start_addr >= ADDR_W'(IOPG_BASE);
    base    = align(bus_trim(start_addr), word_mode);
    lim     = base + span(start_count, word_mode);
    p_kind  = PK_MEM;
    p_first = base;
    p_lim   = lim;
    p_stop  = lim;
    if (io_hit) begin
      p_first = {1'b0, start_addr};
      if (word_mode && (start_addr[0] || start_count[0])) p_kind = PK_REJECT;
      else p_kind = PK_IO;
    end else if (!map_en) begin
      if (lim < mem_size)       p_stop = lim;
      else if (base < mem_size) p_stop = mem_size;
      else                      p_kind = PK_REJECT;
    end
  end
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  plan_kind_e        p_kind,
  input  logic [ADDR_W:0]   p_first,
  input  logic [ADDR_W:0]   p_lim,
  input  logic [ADDR_W:0]   p_stop,
  input  logic [CNT_W-1:0]  start_count,
  input  logic              word_in,
  input  logic              map_in,
  input  logic              dir_in,
  input  logic              ev_end,
  input  logic              ev_fault,
  input  logic              ev_rb_fail,
  output dma_state_e        state,
  output logic [ADDR_W:0]   cur,
  output logic [ADDR_W:0]   stop,
  output logic [CNT_W-1:0]  rem,
  output logic              word,
  output logic              mapped,
  output logic              dir,
  output logic [CNT_W-1:0]  residual
);
  localparam int LIM_W = ADDR_W + 1;

  logic [LIM_W-1:0] lim;

  function automatic logic [CNT_W-1:0] gap(input logic [LIM_W-1:0] hi, input logic [LIM_W-1:0] lo);
    logic [LIM_W-1:0] d;
    d = hi - lo;
    return d[CNT_W-1:0];
  endfunction

  function automatic logic [LIM_W-1:0] stride(input logic w);
    return w ? LIM_W'(2) : LIM_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cur      <= '0;
      lim      <= '0;
      stop     <= '0;
      rem      <= '0;
      word     <= 1'b0;
      mapped   <= 1'b0;
      dir      <= 1'b0;
      residual <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          cur    <= p_first;
          lim    <= p_lim;
          stop   <= p_stop;
          rem    <= start_count;
          word   <= word_in;
          mapped <= map_in;
          dir    <= dir_in;
          unique case (p_kind)
            PK_REJECT: begin residual <= start_count; state <= ST_DONE; end
            PK_IO:     state <= ST_IO;
            default:   state <= ST_MEM;
          endcase
        end
        ST_MEM: begin
          if (ev_end) begin
            residual <= gap(lim, stop);
            state    <= ST_DONE;
          end else if (ev_fault) begin
            residual <= gap(lim, cur);
            state    <= ST_DONE;
          end else begin
            cur <= cur + stride(word);
          end
        end
        ST_IO: begin
          if (ev_end) begin
            residual <= '0;
            state    <= ST_DONE;
          end else if (ev_rb_fail) begin
            residual <= rem;
            state    <= ST_DONE;
          end else begin
            cur <= cur + stride(word);
            rem <= rem - (word ? CNT_W'(2) : CNT_W'(1));
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_portmux.sv
module dma_portmux
  import dma_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int CNT_W = 16
) (
  input  dma_state_e        state,
  input  logic [ADDR_W:0]   cur,
  input  logic [ADDR_W:0]   stop,
  input  logic [CNT_W-1:0]  rem,
  input  logic              word,
  input  logic              mapped,
  input  logic              dir,
  input  logic [ADDR_W:0]   mem_size,
  input  logic [ADDR_W-1:0] xlat_pa,
  input  logic [15:0]       mem_rdata,
  input  logic [15:0]       rb_rdata,
  input  logic              rb_err,
  input  logic [15:0]       st_in_data,
  output logic [ADDR_W-1:0] xlat_addr,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_byte,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_wdata,
  output logic              rb_req,
  output logic              rb_we,
  output logic              rb_byte,
  output logic [ADDR_W-1:0] rb_addr,
  output logic [15:0]       rb_wdata,
  output logic              st_out_valid,
  output logic [15:0]       st_out_data,
  output logic              st_in_take,
  output logic              ev_end,
  output logic              ev_fault,
  output logic              ev_rb_fail,
  output logic              ev_access
);
  logic in_mem, in_io;
  logic [15:0] wr_val;
  logic [15:0] io_val;

  always_comb begin
    in_mem     = state == ST_MEM;
    in_io      = state == ST_IO;
    xlat_addr  = cur[ADDR_W-1:0];
    wr_val     = word ? st_in_data : {8'h00, st_in_data[7:0]};
    ev_end     = 1'b0;
    ev_fault   = 1'b0;
    ev_rb_fail = 1'b0;
    if (in_mem) begin
      ev_end   = cur >= stop;
      ev_fault = !ev_end && mapped && ({1'b0, xlat_pa} >= mem_size);
    end else if (in_io) begin
      ev_end     = rem == '0;
      ev_rb_fail = !ev_end && rb_err;
    end
    ev_access = (in_mem || in_io) && !ev_end && !ev_fault && !ev_rb_fail;

    mem_req   = in_mem && ev_access;
    mem_we    = dir;
    mem_byte  = !word;
    mem_addr  = mapped ? xlat_pa : cur[ADDR_W-1:0];
    mem_wdata = wr_val;

    rb_req   = in_io && !ev_end;
    rb_we    = dir;
    rb_byte  = !word && dir;
    rb_addr  = cur[ADDR_W-1:0];
    if (!dir) rb_addr[0] = 1'b0;
    rb_wdata = wr_val;

    if (word)        io_val = rb_rdata;
    else if (cur[0]) io_val = {8'h00, rb_rdata[15:8]};
    else             io_val = {8'h00, rb_rdata[7:0]};

    st_out_valid = ev_access && !dir;
    st_out_data  = in_io ? io_val : (word ? mem_rdata : {8'h00, mem_rdata[7:0]});
    st_in_take   = ev_access && dir;
  end
endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
  import dma_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int CNT_W = 16,
  parameter int NARROW_W = 18,
  parameter bit WIDE = 1'b0,
  parameter logic [31:0] IOPG_BASE = 32'h003F_E000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  start_count,
  input  logic              dir_wr,
  input  logic              word_mode,
  input  logic              map_en,
  input  logic [ADDR_W:0]   mem_size,
  output logic              busy,
  output logic              done,
  output logic [CNT_W-1:0]  residual,
  output logic [ADDR_W-1:0] xlat_addr,
  input  logic [ADDR_W-1:0] xlat_pa,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_byte,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata,
  output logic              rb_req,
  output logic              rb_we,
  output logic              rb_byte,
  output logic [ADDR_W-1:0] rb_addr,
  output logic [15:0]       rb_wdata,
  input  logic [15:0]       rb_rdata,
  input  logic              rb_err,
  output logic              st_out_valid,
  output logic [15:0]       st_out_data,
  output logic              st_in_take,
  input  logic [15:0]       st_in_data
);
  plan_kind_e        p_kind;
  logic [ADDR_W:0]   p_first, p_lim, p_stop;
  dma_state_e        state;
  logic [ADDR_W:0]   cur, stop;
  logic [CNT_W-1:0]  rem;
  logic              word, mapped, dir;
  logic              ev_end, ev_fault, ev_rb_fail, ev_access;

  dma_plan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .NARROW_W(NARROW_W), .WIDE(WIDE),
             .IOPG_BASE(IOPG_BASE)) u_plan (
    .start_addr(start_addr), .start_count(start_count), .word_mode(word_mode),
    .map_en(map_en), .mem_size(mem_size), .p_kind(p_kind), .p_first(p_first),
    .p_lim(p_lim), .p_stop(p_stop));

  dma_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .p_kind(p_kind), .p_first(p_first),
    .p_lim(p_lim), .p_stop(p_stop), .start_count(start_count), .word_in(word_mode),
    .map_in(map_en), .dir_in(dir_wr), .ev_end(ev_end), .ev_fault(ev_fault),
    .ev_rb_fail(ev_rb_fail), .state(state), .cur(cur), .stop(stop), .rem(rem),
    .word(word), .mapped(mapped), .dir(dir), .residual(residual));

  dma_portmux #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_mux (
    .state(state), .cur(cur), .stop(stop), .rem(rem), .word(word), .mapped(mapped),
    .dir(dir), .mem_size(mem_size), .xlat_pa(xlat_pa), .mem_rdata(mem_rdata),
    .rb_rdata(rb_rdata), .rb_err(rb_err), .st_in_data(st_in_data),
    .xlat_addr(xlat_addr), .mem_req(mem_req), .mem_we(mem_we), .mem_byte(mem_byte),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .rb_req(rb_req), .rb_we(rb_we),
    .rb_byte(rb_byte), .rb_addr(rb_addr), .rb_wdata(rb_wdata),
    .st_out_valid(st_out_valid), .st_out_data(st_out_data), .st_in_take(st_in_take),
    .ev_end(ev_end), .ev_fault(ev_fault), .ev_rb_fail(ev_rb_fail), .ev_access(ev_access));

  assign busy = state != ST_IDLE;
  assign done = state == ST_DONE;
endmodule

// File: rtl/dma_xfer_engine_chk.sv
module dma_xfer_engine_chk #(
  parameter int ADDR_W = 22
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              mem_req,
  input logic              mem_byte,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W:0]   mem_size,
  input logic [ADDR_W-1:0] xlat_addr,
  input logic              rb_req,
  input logic              rb_byte,
  input logic [ADDR_W-1:0] rb_addr,
  input logic              ev_fault,
  input logic              st_out_valid,
  input logic              st_in_take
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !(mem_req || rb_req)); // R11
  AST_MEM_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> ({1'b0, mem_addr} < mem_size)); // R6
  AST_WORD_EVEN: assert property (@(posedge clk) disable iff (!rst_n) (mem_req && !mem_byte) |-> !xlat_addr[0]); // R2
  AST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && $past(mem_req)) |-> (xlat_addr == ($past(xlat_addr) + (mem_byte ? ADDR_W'(1) : ADDR_W'(2))))); // R2
  AST_FAULT_ENDS: assert property (@(posedge clk) disable iff (!rst_n) ev_fault |=> done); // R4
  AST_RB_WORD_EVEN: assert property (@(posedge clk) disable iff (!rst_n) (rb_req && !rb_byte) |-> !rb_addr[0]); // R9
  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n) !(mem_req && rb_req)); // R8
  AST_STREAM_ONE_DIR: assert property (@(posedge clk) disable iff (!rst_n) !(st_out_valid && st_in_take)); // R12
endmodule

bind dma_xfer_engine dma_xfer_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .mem_req(mem_req),
  .mem_byte(mem_byte), .mem_addr(mem_addr), .mem_size(mem_size), .xlat_addr(xlat_addr),
  .rb_req(rb_req), .rb_byte(rb_byte), .rb_addr(rb_addr), .ev_fault(ev_fault),
  .st_out_valid(st_out_valid), .st_in_take(st_in_take));

// File: tb/dma_xfer_engine_test.sv
module dma_xfer_engine_test;
  localparam logic [21:0] IOB = 22'h3FE000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [21:0] start_addr = '0;
  logic [15:0] start_count = '0;
  logic dir_wr = 1'b0, word_mode = 1'b0, map_en = 1'b0;
  logic [22:0] mem_size = 23'h10000;
  logic busy, done;
  logic [15:0] residual;
  logic [21:0] xlat_addr, xlat_pa, mem_addr, rb_addr;
  logic mem_req, mem_we, mem_byte, rb_req, rb_we, rb_byte, rb_err;
  logic [15:0] mem_wdata, mem_rdata, rb_wdata, rb_rdata, st_out_data, st_in_data;
  logic st_out_valid, st_in_take;

  int checks = 0, errors = 0, cycles = 0;
  int take_k = 0;
  logic [21:0] map_base [32];
  logic [47:0] act_log [64];
  logic [47:0] exp_log [64];
  int act_n = 0, exp_n = 0;
  logic [15:0] exp_res;

  always #4 clk = ~clk;

  dma_xfer_engine uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .start_count(start_count), .dir_wr(dir_wr), .word_mode(word_mode), .map_en(map_en),
    .mem_size(mem_size), .busy(busy), .done(done), .residual(residual),
    .xlat_addr(xlat_addr), .xlat_pa(xlat_pa), .mem_req(mem_req), .mem_we(mem_we),
    .mem_byte(mem_byte), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rb_req(rb_req), .rb_we(rb_we), .rb_byte(rb_byte), .rb_addr(rb_addr),
    .rb_wdata(rb_wdata), .rb_rdata(rb_rdata), .rb_err(rb_err),
    .st_out_valid(st_out_valid), .st_out_data(st_out_data), .st_in_take(st_in_take),
    .st_in_data(st_in_data));

  function automatic logic [15:0] wpat(input logic [21:0] a);
    return {a[7:0], a[15:8]} ^ 16'h5AC3;
  endfunction
  function automatic logic [7:0] bpat(input logic [21:0] a);
    return a[7:0] * 8'd3 + a[15:8];
  endfunction
  function automatic logic [15:0] iopat(input logic [21:0] a);
    return {a[7:0] ^ 8'h3C, a[7:0] + 8'h11};
  endfunction
  function automatic logic [15:0] inpat(input int k);
    logic [31:0] v;
    v = (32'h1357 * (k + 1)) ^ 32'h2468;
    return v[15:0];
  endfunction
  function automatic logic io_ok(input logic [22:0] a);
    return (a >= {1'b0, IOB}) && (a - {1'b0, IOB} < 23'd32);
  endfunction
  function automatic logic [22:0] map_of(input logic [22:0] a);
    return {1'b0, map_base[a[17:13]]} + {10'd0, a[12:0]};
  endfunction
  function automatic logic [47:0] ent(input logic k, we, by, input logic [21:0] a, input logic [15:0] d);
    return {7'd0, k, we, by, a, d};
  endfunction

  // environment models
  always_comb begin
    xlat_pa    = map_base[xlat_addr[17:13]] + {9'd0, xlat_addr[12:0]};
    mem_rdata  = mem_byte ? {8'hEE, bpat(mem_addr)} : wpat(mem_addr);
    rb_rdata   = iopat({rb_addr[21:1], 1'b0});
    rb_err     = !io_ok({1'b0, rb_addr});
    st_in_data = inpat(take_k);
  end

  always @(posedge clk) if (st_in_take) take_k <= take_k + 1;

  always @(negedge clk) begin
    if (mem_req && act_n < 64) begin
      act_log[act_n] = ent(1'b0, mem_we, mem_byte, mem_addr, mem_we ? mem_wdata : st_out_data);
      act_n = act_n + 1;
    end
    if (rb_req && !rb_err && act_n < 64) begin
      act_log[act_n] = ent(1'b1, rb_we, rb_byte, rb_addr, rb_we ? rb_wdata : st_out_data);
      act_n = act_n + 1;
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      $display("FAIL R11 watchdog: actual no finish, expected finish");
      $display("CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
      $finish;
    end
  end

  task automatic add_exp(input logic [47:0] e);
    if (exp_n < 64) exp_log[exp_n] = e;
    exp_n++;
  endtask

  // independent model of one transfer
  task automatic predict(input logic [21:0] sa, input logic [15:0] cnt, input logic dw, wd, mp,
                         input logic [22:0] msz, input int k0);
    logic [22:0] a, lim, alim, pa, ea;
    logic [15:0] d;
    int r, k;
    exp_n = 0;
    k = k0;
    if (sa >= IOB) begin
      if (wd && (sa[0] || cnt[0])) begin exp_res = cnt; return; end
      a = {1'b0, sa};
      r = cnt;
      while (r > 0) begin
        if (!io_ok(a)) begin exp_res = 16'(r); return; end
        ea = (dw || wd) ? a : {a[22:1], 1'b0};
        if (dw) begin d = wd ? inpat(k) : {8'h00, inpat(k)[7:0]}; k++; end
        else if (wd) d = iopat(ea[21:0]);
        else d = a[0] ? {8'h00, iopat(ea[21:0])[15:8]} : {8'h00, iopat(ea[21:0])[7:0]};
        add_exp(ent(1'b1, dw, dw && !wd, ea[21:0], d));
        a = a + (wd ? 23'd2 : 23'd1);
        r = r - (wd ? 2 : 1);
      end
      exp_res = 16'd0;
      return;
    end
    a = {5'd0, sa[17:0]};
    if (wd) a[0] = 1'b0;
    lim = a + {7'd0, wd ? {cnt[15:1], 1'b0} : cnt};
    if (mp) alim = lim;
    else if (lim < msz) alim = lim;
    else if (a < msz) alim = msz;
    else begin exp_res = cnt; return; end
    while (a < alim) begin
      pa = mp ? map_of(a) : a;
      if (pa >= msz) begin exp_res = 16'(lim - a); return; end
      if (dw) begin d = wd ? inpat(k) : {8'h00, inpat(k)[7:0]}; k++; end
      else d = wd ? wpat(pa[21:0]) : {8'h00, bpat(pa[21:0])};
      add_exp(ent(1'b0, dw, !wd, pa[21:0], d));
      a = a + (wd ? 23'd2 : 23'd1);
    end
    exp_res = 16'(lim - alim);
  endtask

  // run one transfer; poke: 1 = start mid-run, 2 = start in the done cycle
  task automatic run(input string tag, input logic [21:0] sa, input logic [15:0] cnt,
                     input logic dw, wd, mp, input logic [22:0] msz, input int poke);
    int n;
    logic seen, bad;
    @(negedge clk);
    start_addr = sa; start_count = cnt; dir_wr = dw; word_mode = wd; map_en = mp;
    mem_size = msz;
    predict(sa, cnt, dw, wd, mp, msz, take_k);
    act_n = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < 400; i++) begin
      if (done) begin seen = 1'b1; break; end
      if (poke == 1 && i == 1) begin
        start = 1'b1; start_addr = 22'h000100; start_count = 16'd6; map_en = 1'b0;
      end else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    checks++;
    if (!seen) begin errors++; $display("FAIL %s R11 done: actual 0 expected 1", tag); end
    checks++;
    if (residual !== exp_res) begin
      errors++; $display("FAIL %s residual: actual %0d expected %0d", tag, residual, exp_res);
    end
    if (poke == 2) begin
      start = 1'b1; start_addr = 22'h000200; start_count = 16'd4; map_en = 1'b0;
    end
    n = act_n;
    @(negedge clk);
    start = 1'b0;
    checks++;
    if (done !== 1'b0 || busy !== 1'b0) begin
      errors++; $display("FAIL %s R11 pulse/ignore: actual done=%0b busy=%0b expected 0 0", tag, done, busy);
    end
    checks++;
    bad = (n != exp_n) || (act_n != n);
    for (int i = 0; i < 64; i++) if (i < n && i < exp_n && act_log[i] !== exp_log[i]) bad = 1'b1;
    if (bad) begin
      errors++;
      $display("FAIL %s accesses: actual n=%0d first=%h expected n=%0d first=%h", tag, act_n,
               act_log[0], exp_n, exp_log[0]);
    end
  endtask

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h00C0FFEE);
    for (int i = 0; i < 32; i++) map_base[i] = 22'(i) * 22'h2000;
    repeat (3) @(negedge clk);
    checks++;
    if (busy !== 1'b0 || done !== 1'b0 || residual !== 16'd0 || mem_req !== 1'b0 || rb_req !== 1'b0) begin
      errors++; $display("FAIL R13 reset: actual busy=%0b done=%0b res=%0d expected 0 0 0", busy, done, residual);
    end
    rst_n = 1'b1;

    run("R5 phys word read", 22'h000100, 16'd16, 1'b0, 1'b1, 1'b0, 23'h10000, 0);
    run("R6 phys byte clip", 22'h00FFF8, 16'd20, 1'b0, 1'b0, 1'b0, 23'h10000, 0);
    run("R7 phys bad start", 22'h012000, 16'd10, 1'b0, 1'b1, 1'b0, 23'h10000, 0);
    run("R2 odd addr/count word", 22'h000301, 16'd9, 1'b0, 1'b1, 1'b0, 23'h10000, 0);
    run("R1 trim upper bits", 22'h240100, 16'd8, 1'b0, 1'b1, 1'b0, 23'h10000, 0);
    map_base[1] = 22'h00A000;
    map_base[2] = 22'h00F000;
    run("R3 mapped ok", 22'h002010, 16'd12, 1'b0, 1'b1, 1'b0 | 1'b1, 23'h10000, 0);
    run("R4 mapped fault", 22'h003FF0, 16'd40, 1'b0, 1'b1, 1'b1, 23'h0F008, 0);
    run("R12 mem byte write", 22'h000400, 16'd7, 1'b1, 1'b0, 1'b0, 23'h10000, 0);
    run("R8 io word read", IOB + 22'd4, 16'd8, 1'b0, 1'b1, 1'b0, 23'h10000, 0);
    run("R8 io odd reject", IOB + 22'd3, 16'd8, 1'b0, 1'b1, 1'b0, 23'h10000, 0);
    run("R9 io byte read odd", IOB + 22'd5, 16'd5, 1'b0, 1'b0, 1'b0, 23'h10000, 0);
    run("R9 io byte write", IOB + 22'd9, 16'd4, 1'b1, 1'b0, 1'b0, 23'h10000, 0);
    run("R10 io error", IOB + 22'd26, 16'd12, 1'b0, 1'b1, 1'b0, 23'h10000, 0);
    run("R11 start mid-run", 22'h000800, 16'd10, 1'b0, 1'b0, 1'b0, 23'h10000, 1);
    run("R11 start at done", 22'h000900, 16'd6, 1'b1, 1'b1, 1'b0, 23'h10000, 2);
    run("R5 zero count", 22'h000900, 16'd0, 1'b0, 1'b1, 1'b0, 23'h10000, 0);

    for (int i = 0; i < 32; i++) map_base[i] = 22'($urandom % 24) * 22'h2000;
    for (int t = 0; t < 250; t++) begin
      logic [21:0] sa;
      logic [22:0] msz;
      int sel;
      sel = $urandom % 4;
      if (sel == 0) sa = IOB + 22'($urandom % 40);
      else sa = 22'($urandom % 32'h40000) | ((sel == 3) ? 22'h100000 : 22'h0);
      msz = 23'h1000 * 23'(1 + $urandom % 40) + 23'h80 * 23'($urandom % 2);
      run("R12 rnd", sa, 16'($urandom % 48), 1'($urandom), 1'($urandom), 1'($urandom), msz,
          int'($urandom % 3));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule